// File: doc/BRIEF.md
# Shared-Memory Mailbox Between a Host Controller and a DSP

This block is a word-wide storage window that two processors share. The host controller addresses it in bytes. The DSP addresses it in 16-bit words starting at a fixed base. Both ports reach the same words. Each port has a registered read path with one cycle of latency. Either port can read or write any word in the window. When both ports write the same word in the same cycle, the host write is kept and a sticky collision flag is set.

Six words of the window act as command mailboxes. Each mailbox has a small handshake state machine with two states. It starts in `MB_IDLE`. A non-zero write takes it to `MB_PENDING` (transition POST). A later zero write returns it to `MB_IDLE` (transition ACK). A non-zero write while pending leaves it pending, and a zero write while idle leaves it idle. Three mailboxes are aimed at the DSP: a short command word, a general command word and an upload reply word. The other three are aimed at the host. Each processor has one interrupt line, and it stays high while any mailbox aimed at that processor is pending.

The window also holds a circular receive queue of 100 words. Two words store its tail pointer (next free slot) and its head pointer (oldest entry). The block derives the fill count and the empty and full flags from those two words. DSP access is gated by an enable input. A DSP access made while the gate is closed is refused and latches a fault flag.

Top module: `shmem_mailbox`

## Requirements
- R1: DSP word address `0x0800 + N` and host byte address `2N` (or `2N+1`, since host address bit 0 is ignored) select the same storage word. Read data appears on the rising edge after a read request and is the value stored before any write in that same cycle.
- R2: A mailbox word keeps all 16 bits. The message type in bits 7:0 and the parameter in bits 15:8 read back unchanged on either port.
- R3: The DSP-bound short command mailbox (word 0x60, host byte 0xC0, DSP 0x0860) and general command mailbox (word 0x61, host byte 0xC2, DSP 0x0861) raise `irq_dsp` on the edge after a non-zero write. A zero write from the DSP lowers it again.
- R4: The host-bound mailboxes at words 0x68, 0x69 and 0x6A (host bytes 0xD0/0xD2/0xD4, DSP 0x0868/0x0869/0x086A) raise `irq_host` after a non-zero write. A zero write from the host lowers it.
- R5: The upload reply word (word 0x62, host byte 0xC4, DSP 0x0862) goes pending when the host writes a non-zero acknowledge, which drives `irq_dsp`. It returns to idle when the DSP writes zero.
- R6: Each interrupt stays high while at least one mailbox in its group is non-zero, even after other mailboxes in that group have been cleared.
- R7: The tail pointer is word 0xF0 (host byte 0x1E0) and the head pointer is word 0xF1 (host byte 0x1E2). `q_count` = (tail − head) mod 100. `q_empty` is high when tail equals head. `q_full` is high when the count is 99.
- R8: While `share_en` is low, a DSP access is refused: its write is dropped and its read returns 0. Any DSP access in that state sets `d_fault`, which stays set until reset.
- R9: If both ports write the same word in one cycle, the host value is stored and `coll_flag` sets and stays set until reset. Writes to different words in one cycle both take effect and leave `coll_flag` low.
- R10: After reset, all words are 0, both interrupts and both flags are low, both read buses are 0, and the queue reports empty.
- R11: With the gate open, a DSP address outside `0x0800`..`0x08FF` changes no word, reads 0, and does not set `d_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_en | input | 1 | Opens the DSP side of the window |
| h_en | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 9 | Host byte address; bit 0 ignored |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, registered |
| d_en | input | 1 | DSP access request |
| d_we | input | 1 | DSP write (1) or read (0) |
| d_addr | input | 16 | DSP word address |
| d_wdata | input | 16 | DSP write data |
| d_rdata | output | 16 | DSP read data, registered |
| irq_dsp | output | 1 | A DSP-bound mailbox is pending |
| irq_host | output | 1 | A host-bound mailbox is pending |
| d_fault | output | 1 | Sticky: DSP access made while the gate was closed |
| coll_flag | output | 1 | Sticky: same-word write collision |
| q_count | output | 7 | Words held in the receive queue |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue holds 99 words |

## Verification
The bench writes through one port and reads through the other, including at the top word of the window and at an odd host address. An address-translation error therefore shows up as wrong read data. It lets the queue pointers wrap across the end of the 100-word ring and hit the 99-word full point, where a count that is not taken modulo 100 would be badly off. It clears one of two pending mailboxes and checks that the interrupt stays high, which catches an interrupt tied to the most recent write. It also sends a DSP write just outside the window to a word that would alias onto word 0, sends writes into a closed window, and makes both ports write the same word at once. A missing range check, a missing gate, or the DSP winning a collision would each change a word the bench reads back.

// File: rtl/shmbx_pkg.sv
package shmbx_pkg;
    localparam int WORD_W  = 16;
    localparam int NUM_MBX = 6;
    // word index of each mailbox; entries 0..2 raise the DSP line, 3..5 the host line
    localparam logic [7:0] MBX_IDX [NUM_MBX] = '{8'h60, 8'h61, 8'h62, 8'h68, 8'h69, 8'h6A};
    localparam logic [NUM_MBX-1:0] MBX_TO_DSP = 6'b000111;
    localparam logic [7:0] QTAIL_IDX = 8'hF0;
    localparam logic [7:0] QHEAD_IDX = 8'hF1;

    typedef enum logic {
        MB_IDLE,
        MB_PENDING
    } mb_state_e;
endpackage

// File: rtl/shmbx_cell.sv
module shmbx_cell
    import shmbx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] word,
    output logic         pending
);
    mb_state_e st_q, st_d;
    logic [W-1:0] word_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MB_IDLE;
        else        st_q <= st_d;
    end

    // next state: POST on non-zero write, ACK on zero write
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MB_IDLE:    if (wr_en && (wr_data != '0)) st_d = MB_PENDING;
            MB_PENDING: if (wr_en && (wr_data == '0)) st_d = MB_IDLE;
            default:    st_d = MB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= '0;
        else if (wr_en) word_q <= wr_data;
    end

    // outputs
    always_comb begin
        pending = (st_q == MB_PENDING);
        word    = word_q;
    end
endmodule

// File: rtl/shmbx_ram.sv
module shmbx_ram #(
    parameter int DEPTH = 256,
    parameter int W     = 16,
    parameter int TAIL  = 240,
    parameter int HEAD  = 241,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [IW-1:0] a_idx,
    input  logic [W-1:0]  a_wd,
    input  logic          b_we,
    input  logic [IW-1:0] b_idx,
    input  logic [W-1:0]  b_wd,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    output logic [W-1:0]  tail_word,
    output logic [W-1:0]  head_word
);
    logic [W-1:0] mem [DEPTH];

    // port a is applied last so it wins on a shared index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (b_we) mem[b_idx] <= b_wd;
            if (a_we) mem[a_idx] <= a_wd;
        end
    end

    assign ra_data   = mem[ra_idx];
    assign rb_data   = mem[rb_idx];
    assign tail_word = mem[TAIL];
    assign head_word = mem[HEAD];
endmodule

// File: rtl/shmbx_qstat.sv
module shmbx_qstat #(
    parameter int QLEN = 100,
    localparam int PW  = $clog2(QLEN)
) (
    input  logic [PW-1:0] tail,
    input  logic [PW-1:0] head,
    output logic [PW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam logic [PW-1:0] QLEN_V = PW'(QLEN);
    localparam logic [PW-1:0] QMAX_V = PW'(QLEN - 1);

    always_comb begin
        if (tail >= head) count = tail - head;
        else              count = QLEN_V - head + tail;
        empty = (tail == head);
        full  = (count == QMAX_V);
    end
endmodule

// File: rtl/shmem_mailbox.sv
module shmem_mailbox
    import shmbx_pkg::*;
#(
    parameter int          DEPTH    = 256,
    parameter logic [15:0] DSP_BASE = 16'h0800,
    parameter int          QLEN     = 100,
    localparam int IW  = $clog2(DEPTH),
    localparam int HAW = IW + 1,
    localparam int QPW = $clog2(QLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              share_en,
    input  logic              h_en,
    input  logic              h_we,
    input  logic [HAW-1:0]    h_addr,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_rdata,
    input  logic              d_en,
    input  logic              d_we,
    input  logic [15:0]       d_addr,
    input  logic [WORD_W-1:0] d_wdata,
    output logic [WORD_W-1:0] d_rdata,
    output logic              irq_dsp,
    output logic              irq_host,
    output logic              d_fault,
    output logic              coll_flag,
    output logic [QPW-1:0]    q_count,
    output logic              q_empty,
    output logic              q_full
);
    logic [IW-1:0]     h_idx, d_idx;
    logic [15:0]       d_off;
    logic              d_in_win, d_ok, h_wr, d_wr, same_word;
    logic [WORD_W-1:0] ram_h, ram_d, h_word, d_word, tail_w, head_w;
    logic [WORD_W-1:0] cell_word [NUM_MBX];
    logic [NUM_MBX-1:0] cell_pend;

    assign h_idx     = h_addr[HAW-1:1];
    assign d_off     = d_addr - DSP_BASE;
    assign d_in_win  = (d_off < 16'(DEPTH));
    assign d_idx     = d_off[IW-1:0];
    assign d_ok      = d_en && share_en && d_in_win;
    assign h_wr      = h_en && h_we;
    assign d_wr      = d_ok && d_we;
    assign same_word = (h_idx == d_idx);

    shmbx_ram #(
        .DEPTH(DEPTH), .W(WORD_W),
        .TAIL(int'(QTAIL_IDX)), .HEAD(int'(QHEAD_IDX))
    ) ram_i (
        .clk(clk), .rst_n(rst_n),
        .a_we(h_wr), .a_idx(h_idx), .a_wd(h_wdata),
        .b_we(d_wr), .b_idx(d_idx), .b_wd(d_wdata),
        .ra_idx(h_idx), .ra_data(ram_h),
        .rb_idx(d_idx), .rb_data(ram_d),
        .tail_word(tail_w), .head_word(head_w)
    );

    for (genvar g = 0; g < NUM_MBX; g++) begin : g_mbx
        logic h_hit, d_hit;
        assign h_hit = h_wr && (int'(h_idx) == int'(MBX_IDX[g]));
        assign d_hit = d_wr && (int'(d_idx) == int'(MBX_IDX[g]));
        shmbx_cell #(.W(WORD_W)) cell_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(h_hit || d_hit),
            .wr_data(h_hit ? h_wdata : d_wdata),
            .word(cell_word[g]),
            .pending(cell_pend[g])
        );
    end

    // mailbox words take precedence over the plain store on reads
    always_comb begin
        h_word = ram_h;
        d_word = ram_d;
        for (int i = 0; i < NUM_MBX; i++) begin
            if (int'(h_idx) == int'(MBX_IDX[i])) h_word = cell_word[i];
            if (int'(d_idx) == int'(MBX_IDX[i])) d_word = cell_word[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata   <= '0;
            d_rdata   <= '0;
            d_fault   <= 1'b0;
            coll_flag <= 1'b0;
        end else begin
            if (h_en && !h_we)                d_rdata <= d_rdata;
            if (h_en && !h_we)                h_rdata <= h_word;
            if (d_en && !d_we)                d_rdata <= d_ok ? d_word : '0;
            if (d_en && !share_en)            d_fault <= 1'b1;
            if (h_wr && d_wr && same_word)    coll_flag <= 1'b1;
        end
    end

    assign irq_dsp  = |(cell_pend & MBX_TO_DSP);
    assign irq_host = |(cell_pend & ~MBX_TO_DSP);

    shmbx_qstat #(.QLEN(QLEN)) qstat_i (
        .tail(tail_w[QPW-1:0]), .head(head_w[QPW-1:0]),
        .count(q_count), .empty(q_empty), .full(q_full)
    );

    logic unused_bits;
    assign unused_bits = ^{h_addr[0], d_off[15:IW], tail_w[WORD_W-1:QPW], head_w[WORD_W-1:QPW]};
endmodule

// File: rtl/shmbx_checker.sv
module shmbx_checker
    import shmbx_pkg::*;
#(
    parameter int          HAW      = 9,
    parameter int          QPW      = 7,
    parameter logic [15:0] DSP_BASE = 16'h0800
) (
    input logic           clk,
    input logic           rst_n,
    input logic           share_en,
    input logic           h_en,
    input logic           h_we,
    input logic [HAW-1:0] h_addr,
    input logic [15:0]    h_wdata,
    input logic           d_en,
    input logic           d_we,
    input logic [15:0]    d_addr,
    input logic [15:0]    d_wdata,
    input logic [15:0]    d_rdata,
    input logic           irq_dsp,
    input logic           irq_host,
    input logic           d_fault,
    input logic           coll_flag,
    input logic [QPW-1:0] q_count,
    input logic           q_empty,
    input logic           q_full
);
    logic h_to_dsp_mbx, d_to_host_mbx, h_on_host_mbx;
    assign h_to_dsp_mbx  = h_en && h_we && (int'(h_addr[HAW-1:1]) == int'(MBX_IDX[0])) && (h_wdata != '0);
    assign h_on_host_mbx = h_en && h_we && (int'(h_addr[HAW-1:1]) == int'(MBX_IDX[3]));
    assign d_to_host_mbx = d_en && d_we && share_en && (d_wdata != '0)
                           && (d_addr == DSP_BASE + 16'(MBX_IDX[3]));

    p_post_dsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        h_to_dsp_mbx |=> irq_dsp);

    p_post_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_to_host_mbx && !h_on_host_mbx) |=> irq_host);

    p_qflags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_full, q_empty}));

    p_empty_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (q_count == '0));

    p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_en && !share_en) |=> d_fault);

    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        d_fault |=> d_fault);

    p_refused_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_en && !d_we && !share_en) |=> (d_rdata == '0));

    p_coll_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        coll_flag |=> coll_flag);

    p_irq_reset_r10: assert property (@(posedge clk)
        $past(!rst_n) |-> (!irq_dsp && !irq_host && !d_fault && !coll_flag));
endmodule

bind shmem_mailbox shmbx_checker #(.HAW(HAW), .QPW(QPW), .DSP_BASE(DSP_BASE)) chk_i (
    .clk(clk), .rst_n(rst_n), .share_en(share_en),
    .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .d_en(d_en), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
    .irq_dsp(irq_dsp), .irq_host(irq_host), .d_fault(d_fault), .coll_flag(coll_flag),
    .q_count(q_count), .q_empty(q_empty), .q_full(q_full)
);

// File: tb/shmem_mailbox_tb_top.sv
`timescale 1ns/1ps
module shmem_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        share_en = 1'b1;
    logic        h_en = 1'b0, h_we = 1'b0;
    logic [8:0]  h_addr = '0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        d_en = 1'b0, d_we = 1'b0;
    logic [15:0] d_addr = '0;
    logic [15:0] d_wdata = '0;
    logic [15:0] d_rdata;
    logic        irq_dsp, irq_host, d_fault, coll_flag, q_empty, q_full;
    logic [6:0]  q_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    shmem_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .share_en(share_en),
        .h_en(h_en), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .d_en(d_en), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .irq_dsp(irq_dsp), .irq_host(irq_host), .d_fault(d_fault), .coll_flag(coll_flag),
        .q_count(q_count), .q_empty(q_empty), .q_full(q_full)
    );

    // op codes: 0 host write, 1 host read, 2 DSP write, 3 DSP read
    localparam logic [33:0] VEC [8] = '{
        {2'd0, 16'h0010, 16'h1234},
        {2'd3, 16'h0808, 16'h1234},
        {2'd2, 16'h0809, 16'hBEEF},
        {2'd1, 16'h0012, 16'hBEEF},
        {2'd1, 16'h0013, 16'hBEEF},
        {2'd0, 16'h01FE, 16'h5A5A},
        {2'd3, 16'h08FF, 16'h5A5A},
        {2'd1, 16'h0000, 16'h0000}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); h_en = 1; h_we = 1; h_addr = a[8:0]; h_wdata = d;
        @(negedge clk); h_en = 0; h_we = 0;
    endtask

    task automatic dw(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); d_en = 1; d_we = 1; d_addr = a; d_wdata = d;
        @(negedge clk); d_en = 0; d_we = 0;
    endtask

    task automatic hr(input logic [15:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); h_en = 1; h_we = 0; h_addr = a[8:0];
        @(negedge clk); chk(h_rdata, exp, req); h_en = 0;
    endtask

    task automatic dr(input logic [15:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); d_en = 1; d_we = 0; d_addr = a;
        @(negedge clk); chk(d_rdata, exp, req); d_en = 0;
    endtask

    task automatic both_w(input logic [15:0] ha, input logic [15:0] hd,
                          input logic [15:0] da, input logic [15:0] dd);
        @(negedge clk);
        h_en = 1; h_we = 1; h_addr = ha[8:0]; h_wdata = hd;
        d_en = 1; d_we = 1; d_addr = da; d_wdata = dd;
        @(negedge clk); h_en = 0; h_we = 0; d_en = 0; d_we = 0;
    endtask

    task automatic qset(input logic [15:0] t, input logic [15:0] h);
        hw(16'h01E0, t);
        hw(16'h01E2, h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        chk({15'd0, irq_dsp}, 16'd0, "R10 irq_dsp");
        chk({15'd0, irq_host}, 16'd0, "R10 irq_host");
        chk({15'd0, d_fault}, 16'd0, "R10 d_fault");
        chk({15'd0, coll_flag}, 16'd0, "R10 coll_flag");
        chk(h_rdata, 16'd0, "R10 h_rdata");
        chk(d_rdata, 16'd0, "R10 d_rdata");
        chk({15'd0, q_empty}, 16'd1, "R10 q_empty");
        chk({9'd0, q_count}, 16'd0, "R10 q_count");

        // R1 vector walk across both ports
        foreach (VEC[i]) begin
            unique case (VEC[i][33:32])
                2'd0: hw(VEC[i][31:16], VEC[i][15:0]);
                2'd1: hr(VEC[i][31:16], VEC[i][15:0], "R1");
                2'd2: dw(VEC[i][31:16], VEC[i][15:0]);
                default: dr(VEC[i][31:16], VEC[i][15:0], "R1");
            endcase
        end

        // R3 / R2 short command to DSP
        hw(16'h00C0, 16'h0305);
        chk({15'd0, irq_dsp}, 16'd1, "R3 post");
        chk({15'd0, irq_host}, 16'd0, "R3 other line");
        dr(16'h0860, 16'h0305, "R2 type/param");
        dw(16'h0860, 16'h0000);
        chk({15'd0, irq_dsp}, 16'd0, "R3 ack");

        // R6 two pending on DSP line
        hw(16'h00C0, 16'h0011);
        hw(16'h00C2, 16'h2201);
        dw(16'h0860, 16'h0000);
        chk({15'd0, irq_dsp}, 16'd1, "R6 one still pending");
        dw(16'h0861, 16'h0000);
        chk({15'd0, irq_dsp}, 16'd0, "R6 all cleared");

        // R5 upload reply
        hw(16'h00C4, 16'h0001);
        chk({15'd0, irq_dsp}, 16'd1, "R5 ack posted");
        dw(16'h0862, 16'h0000);
        chk({15'd0, irq_dsp}, 16'd0, "R5 dsp ready");

        // R4 host-bound mailboxes
        dw(16'h0869, 16'hA714);
        chk({15'd0, irq_host}, 16'd1, "R4 post");
        hr(16'h00D2, 16'hA714, "R2 host view");
        hw(16'h00D2, 16'h0000);
        chk({15'd0, irq_host}, 16'd0, "R4 ack");

        // R7 queue arithmetic
        qset(16'd5, 16'd5);
        chk({15'd0, q_empty}, 16'd1, "R7 empty");
        qset(16'd10, 16'd3);
        chk({9'd0, q_count}, 16'd7, "R7 count");
        chk({15'd0, q_full}, 16'd0, "R7 not full");
        qset(16'd3, 16'd90);
        chk({9'd0, q_count}, 16'd13, "R7 wrap count");
        qset(16'd2, 16'd3);
        chk({9'd0, q_count}, 16'd99, "R7 full count");
        chk({15'd0, q_full}, 16'd1, "R7 full wrap");
        qset(16'd99, 16'd0);
        chk({15'd0, q_full}, 16'd1, "R7 full edge");

        // R9 collisions
        both_w(16'h0040, 16'hAAAA, 16'h0821, 16'hBBBB);
        chk({15'd0, coll_flag}, 16'd0, "R9 no collision");
        hr(16'h0040, 16'hAAAA, "R9 host word");
        hr(16'h0042, 16'hBBBB, "R9 dsp word");
        both_w(16'h0040, 16'h1111, 16'h0820, 16'h2222);
        chk({15'd0, coll_flag}, 16'd1, "R9 collision flag");
        dr(16'h0820, 16'h1111, "R9 host wins");

        // R11 outside window
        dw(16'h0900, 16'h7777);
        dw(16'h07FF, 16'h6666);
        hr(16'h0000, 16'h0000, "R11 no alias low");
        hr(16'h01FE, 16'h5A5A, "R11 no alias high");
        dr(16'h0808, 16'h1234, "R11 prime");
        dr(16'h0900, 16'h0000, "R11 read zero");
        chk({15'd0, d_fault}, 16'd0, "R11 no fault");

        // R8 closed gate
        share_en = 0;
        dw(16'h0808, 16'hFFFF);
        chk({15'd0, d_fault}, 16'd1, "R8 fault set");
        hr(16'h0010, 16'h1234, "R8 write dropped");
        dr(16'h0808, 16'h0000, "R8 refused read");
        dw(16'h0868, 16'h0042);
        chk({15'd0, irq_host}, 16'd0, "R8 no mailbox post");
        share_en = 1;
        @(negedge clk);
        chk({15'd0, d_fault}, 16'd1, "R8 sticky");
        dr(16'h0808, 16'h1234, "R8 reopened");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule